// File: doc/BRIEF.md
# Serial Port Bit-Clock Manager

This block produces the internal bit clocks for the transmit and receive sides of a synchronous serial port. It also controls the two clock pads. A programmable divider derives a square wave from the master clock. Each direction then selects its clock from three sources: that divided wave, the clock of the other direction, or its own pad after the pad has been synchronized into the master-clock domain. The selected level can be inverted for internal use, and a rising-edge pulse is produced from it so that shift logic can run on master-clock enables. The pad can be driven with the divided wave all the time, driven only while a transfer is active, or left undriven. Inversion never reaches the pad.

Two configurations are resolved in hardware instead of being left undefined. The first is a pad chosen as the clock source while continuous drive is enabled on that same pad. The second is both directions selecting each other. In both cases a sticky error flag is raised. The divider is a three-state machine: `DV_IDLE` moves to `DV_LOW` when the divide value is non-zero, `DV_LOW` and `DV_HIGH` alternate after each completed phase, and any state returns to `DV_IDLE` when the divide value is zero. The error tracker has two states: `CFG_OK` moves to `CFG_FAULT` when an illegal configuration is sampled, and `CFG_FAULT` holds until reset.

Top module: `sclk_mgr`

## Requirements
- R1: With divide value D (1 to 4095), the divided clock spends exactly D master cycles low and then D master cycles high, a period of 2*D. After D changes from zero, the first high phase becomes visible D+1 master edges later.
- R2: A divide value of zero returns the divider to idle at the next edge and holds the divided clock low.
- R3: The source field of each direction selects 0 = divided clock, 1 = the other direction's clock before its inversion, 2 = that direction's own synchronized pad, 3 = divided clock.
- R4: A pad level passes two flip-flops before it appears on the internal clock. The level is visible after the second master edge following the pad change. The rise pulse is high for exactly that one cycle.
- R5: The internal clock of each direction equals the selected source XOR that direction's invert bit.
- R6: The invert bit has no effect on the pad output. A driven pad always carries the uninverted divided clock.
- R7: The pad-mode field selects 0 = undriven, 1 = driven continuously, 2 = driven only while that direction's active strobe is high, 3 = undriven. An undriven pad outputs 0.
- R8: Pad source (2) together with continuous drive (1) on the same direction leaves that pad undriven.
- R9: When both directions select source 1, both internal clocks use the divided clock.
- R10: The error flag is 0 after reset. It rises one edge after an R8 or R9 configuration is sampled and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_val | input | DIV_W | Divide value; phase length in master cycles |
| tx_src | input | 2 | Transmit clock source select |
| tx_inv | input | 1 | Transmit internal clock invert |
| tx_mode | input | 2 | Transmit pad drive mode |
| tx_active | input | 1 | Transmit transfer in progress |
| tx_pad_in | input | 1 | Transmit clock pad input |
| rx_src | input | 2 | Receive clock source select |
| rx_inv | input | 1 | Receive internal clock invert |
| rx_mode | input | 2 | Receive pad drive mode |
| rx_active | input | 1 | Receive transfer in progress |
| rx_pad_in | input | 1 | Receive clock pad input |
| tx_clk | output | 1 | Transmit internal clock level |
| tx_rise | output | 1 | Transmit internal clock rise pulse |
| tx_pad_out | output | 1 | Transmit pad output value |
| tx_pad_oe | output | 1 | Transmit pad output enable |
| rx_clk | output | 1 | Receive internal clock level |
| rx_rise | output | 1 | Receive internal clock rise pulse |
| rx_pad_out | output | 1 | Receive pad output value |
| rx_pad_oe | output | 1 | Receive pad output enable |
| cfg_err | output | 1 | Sticky illegal-configuration flag |

## Verification
Routing, inversion and pad enable follow the mode inputs in the same cycle, so the bench checks them one settling delay after it drives the inputs. A pad change is checked as absent after one master edge, present with its rise pulse after two, and with the pulse gone after three. The error flag is checked one edge after the bad setting, and checked again after the setting is withdrawn. Divider phases are measured by counting consecutive samples taken one per master cycle, and the first high phase is expected D+1 edges after the divide value leaves zero.

// File: rtl/sclk_pkg.sv
package sclk_pkg;
    typedef enum logic [1:0] {
        SRC_DIV  = 2'd0,
        SRC_PEER = 2'd1,
        SRC_PAD  = 2'd2,
        SRC_RSV  = 2'd3
    } src_e;

    typedef enum logic [1:0] {
        PAD_OFF  = 2'd0,
        PAD_CONT = 2'd1,
        PAD_XFER = 2'd2,
        PAD_RSV  = 2'd3
    } pad_e;

    typedef enum logic [1:0] {
        DV_IDLE = 2'd0,
        DV_LOW  = 2'd1,
        DV_HIGH = 2'd2
    } div_st_e;

    typedef enum logic {
        CFG_OK    = 1'b0,
        CFG_FAULT = 1'b1
    } cfg_st_e;
endpackage

// File: rtl/sclk_div.sv
module sclk_div
    import sclk_pkg::*;
#(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_val,
    output logic             div_clk
);
    localparam int CW = DIV_W + 1;

    div_st_e          state, state_nxt;
    logic [DIV_W-1:0] cnt, cnt_nxt;
    logic             phase_done;

    assign phase_done = ({1'b0, cnt} + CW'(1)) >= {1'b0, div_val};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= DV_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt;
        if (div_val == '0) begin
            state_nxt = DV_IDLE;
            cnt_nxt   = '0;
        end else begin
            unique case (state)
                DV_IDLE: begin
                    state_nxt = DV_LOW;
                    cnt_nxt   = '0;
                end
                DV_LOW: begin
                    if (phase_done) begin
                        state_nxt = DV_HIGH;
                        cnt_nxt   = '0;
                    end else begin
                        cnt_nxt = cnt + 1'b1;
                    end
                end
                DV_HIGH: begin
                    if (phase_done) begin
                        state_nxt = DV_LOW;
                        cnt_nxt   = '0;
                    end else begin
                        cnt_nxt = cnt + 1'b1;
                    end
                end
                default: begin
                    state_nxt = DV_IDLE;
                    cnt_nxt   = '0;
                end
            endcase
        end
    end

    always_comb begin
        unique case (state)
            DV_HIGH: div_clk = 1'b1;
            default: div_clk = 1'b0;
        endcase
    end
endmodule

// File: rtl/sclk_sync.sv
module sclk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pad_in,
    output logic pad_sync
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], pad_in};
    end

    assign pad_sync = chain[STAGES-1];
endmodule

// File: rtl/sclk_dir.sv
module sclk_dir
    import sclk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       div_clk,
    input  logic       pad_sync,
    input  logic       peer_own,
    input  logic       peer_wants_me,
    input  logic [1:0] src,
    input  logic       inv,
    input  logic [1:0] mode,
    input  logic       active,
    output logic       own_base,
    output logic       clk_int,
    output logic       rise,
    output logic       pad_out,
    output logic       pad_oe,
    output logic       bad_cfg
);
    src_e src_s;
    pad_e mode_s;
    logic sel_clk, clk_q, mutual, contend;

    assign src_s  = src_e'(src);
    assign mode_s = pad_e'(mode);

    assign mutual  = (src_s == SRC_PEER) && peer_wants_me;
    assign contend = (src_s == SRC_PAD) && (mode_s == PAD_CONT);
    assign bad_cfg = mutual | contend;

    // Clock this direction offers its peer: never the peer's own clock.
    assign own_base = (src_s == SRC_PAD) ? pad_sync : div_clk;

    always_comb begin
        unique case (src_s)
            SRC_PEER: sel_clk = mutual ? div_clk : peer_own;
            SRC_PAD:  sel_clk = pad_sync;
            default:  sel_clk = div_clk;
        endcase
    end

    assign clk_int = sel_clk ^ inv;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) clk_q <= 1'b0;
        else        clk_q <= clk_int;
    end

    assign rise = clk_int & ~clk_q;

    always_comb begin
        unique case (mode_s)
            PAD_CONT: pad_oe = ~contend;
            PAD_XFER: pad_oe = active;
            default:  pad_oe = 1'b0;
        endcase
    end

    assign pad_out = pad_oe & div_clk;
endmodule

// File: rtl/sclk_mgr.sv
module sclk_mgr
    import sclk_pkg::*;
#(
    parameter int DIV_W       = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_val,
    input  logic [1:0]       tx_src,
    input  logic             tx_inv,
    input  logic [1:0]       tx_mode,
    input  logic             tx_active,
    input  logic             tx_pad_in,
    input  logic [1:0]       rx_src,
    input  logic             rx_inv,
    input  logic [1:0]       rx_mode,
    input  logic             rx_active,
    input  logic             rx_pad_in,
    output logic             tx_clk,
    output logic             tx_rise,
    output logic             tx_pad_out,
    output logic             tx_pad_oe,
    output logic             rx_clk,
    output logic             rx_rise,
    output logic             rx_pad_out,
    output logic             rx_pad_oe,
    output logic             cfg_err
);
    localparam int NDIR = 2;

    logic             div_clk;
    logic [NDIR-1:0]  pad_raw, pad_sync;
    logic             tx_own, rx_own, tx_bad, rx_bad;
    cfg_st_e          cfg_st, cfg_st_nxt;

    sclk_div #(.DIV_W(DIV_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .div_val (div_val),
        .div_clk (div_clk)
    );

    assign pad_raw = {rx_pad_in, tx_pad_in};

    for (genvar d = 0; d < NDIR; d++) begin : g_sync
        sclk_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk      (clk),
            .rst_n    (rst_n),
            .pad_in   (pad_raw[d]),
            .pad_sync (pad_sync[d])
        );
    end

    sclk_dir u_tx (
        .clk           (clk),
        .rst_n         (rst_n),
        .div_clk       (div_clk),
        .pad_sync      (pad_sync[0]),
        .peer_own      (rx_own),
        .peer_wants_me (rx_src == SRC_PEER),
        .src           (tx_src),
        .inv           (tx_inv),
        .mode          (tx_mode),
        .active        (tx_active),
        .own_base      (tx_own),
        .clk_int       (tx_clk),
        .rise          (tx_rise),
        .pad_out       (tx_pad_out),
        .pad_oe        (tx_pad_oe),
        .bad_cfg       (tx_bad)
    );

    sclk_dir u_rx (
        .clk           (clk),
        .rst_n         (rst_n),
        .div_clk       (div_clk),
        .pad_sync      (pad_sync[1]),
        .peer_own      (tx_own),
        .peer_wants_me (tx_src == SRC_PEER),
        .src           (rx_src),
        .inv           (rx_inv),
        .mode          (rx_mode),
        .active        (rx_active),
        .own_base      (rx_own),
        .clk_int       (rx_clk),
        .rise          (rx_rise),
        .pad_out       (rx_pad_out),
        .pad_oe        (rx_pad_oe),
        .bad_cfg       (rx_bad)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_st <= CFG_OK;
        else        cfg_st <= cfg_st_nxt;
    end

    always_comb begin
        unique case (cfg_st)
            CFG_OK:    cfg_st_nxt = (tx_bad | rx_bad) ? CFG_FAULT : CFG_OK;
            CFG_FAULT: cfg_st_nxt = CFG_FAULT;
            default:   cfg_st_nxt = CFG_OK;
        endcase
    end

    always_comb begin
        unique case (cfg_st)
            CFG_FAULT: cfg_err = 1'b1;
            default:   cfg_err = 1'b0;
        endcase
    end
endmodule

// File: rtl/sclk_mgr_chk.sv
module sclk_mgr_chk #(
    parameter int DIV_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic [DIV_W-1:0] div_val,
    input logic [1:0]       tx_src,
    input logic [1:0]       tx_mode,
    input logic             tx_active,
    input logic             tx_pad_out,
    input logic             tx_pad_oe,
    input logic [1:0]       rx_src,
    input logic [1:0]       rx_mode,
    input logic             rx_pad_oe,
    input logic             div_clk,
    input logic             cfg_err
);
    logic illegal;
    assign illegal = (tx_src == 2'd2 && tx_mode == 2'd1) ||
                     (rx_src == 2'd2 && rx_mode == 2'd1) ||
                     (tx_src == 2'd1 && rx_src == 2'd1);

    // R8
    tx_contend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_src == 2'd2 && tx_mode == 2'd1) |-> !tx_pad_oe);

    // R8
    rx_contend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_src == 2'd2 && rx_mode == 2'd1) |-> !rx_pad_oe);

    // R10
    err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |=> cfg_err);

    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err);

    // R2
    div_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (div_val == '0) |=> !div_clk);

    // R6
    pad_noinv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pad_oe |-> (tx_pad_out == div_clk));

    // R7
    xfer_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_mode == 2'd2) |-> (tx_pad_oe == tx_active));

    // R7
    pad_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_mode == 2'd0 || tx_mode == 2'd3) |-> !tx_pad_oe);
endmodule

bind sclk_mgr sclk_mgr_chk #(.DIV_W(DIV_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .div_val    (div_val),
    .tx_src     (tx_src),
    .tx_mode    (tx_mode),
    .tx_active  (tx_active),
    .tx_pad_out (tx_pad_out),
    .tx_pad_oe  (tx_pad_oe),
    .rx_src     (rx_src),
    .rx_mode    (rx_mode),
    .rx_pad_oe  (rx_pad_oe),
    .div_clk    (div_clk),
    .cfg_err    (cfg_err)
);

// File: tb/sclk_mgr_bench.sv
`timescale 1ns/1ps
module sclk_mgr_bench;
    localparam int DIV_W = 12;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [DIV_W-1:0] div_val = '0;
    logic [1:0]       tx_src = '0, tx_mode = '0, rx_src = '0, rx_mode = '0;
    logic             tx_inv = 0, tx_active = 0, tx_pad_in = 0;
    logic             rx_inv = 0, rx_active = 0, rx_pad_in = 0;
    logic             tx_clk, tx_rise, tx_pad_out, tx_pad_oe;
    logic             rx_clk, rx_rise, rx_pad_out, rx_pad_oe, cfg_err;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    sclk_mgr #(.DIV_W(DIV_W)) u_sclk_mgr (
        .clk(clk), .rst_n(rst_n), .div_val(div_val),
        .tx_src(tx_src), .tx_inv(tx_inv), .tx_mode(tx_mode),
        .tx_active(tx_active), .tx_pad_in(tx_pad_in),
        .rx_src(rx_src), .rx_inv(rx_inv), .rx_mode(rx_mode),
        .rx_active(rx_active), .rx_pad_in(rx_pad_in),
        .tx_clk(tx_clk), .tx_rise(tx_rise), .tx_pad_out(tx_pad_out),
        .tx_pad_oe(tx_pad_oe), .rx_clk(rx_clk), .rx_rise(rx_rise),
        .rx_pad_out(rx_pad_out), .rx_pad_oe(rx_pad_oe), .cfg_err(cfg_err)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // advance n edges, then settle 2 ns past the edge
    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic settle();
        #1;
    endtask

    task automatic do_reset();
        rst_n = 0;
        div_val = '0; tx_src = 0; tx_mode = 0; rx_src = 0; rx_mode = 0;
        tx_inv = 0; rx_inv = 0; tx_active = 0; rx_active = 0;
        tx_pad_in = 0; rx_pad_in = 0;
        tick(2);
        rst_n = 1;
        tick(1);
    endtask

    task automatic t_reset();
        rst_n = 0;
        tick(1);
        chk("R10 reset err", cfg_err, 0);
        chk("R7 reset tx oe", tx_pad_oe, 0);
        chk("R2 reset tx clk", tx_clk, 0);
        do_reset();
    endtask

    task automatic t_divider(input int d);
        int hi = 0;
        int lo = 0;
        int guard = 0;
        do_reset();
        div_val = DIV_W'(d);
        tick(d);
        chk("R1 first low phase", tx_clk, 0);
        tick(1);
        chk("R1 first high at D+1", tx_clk, 1);
        while (tx_clk == 1 && guard < 10000) begin hi++; guard++; tick(1); end
        while (tx_clk == 0 && guard < 20000) begin lo++; guard++; tick(1); end
        chk("R1 high phase length", hi, d);
        chk("R1 low phase length", lo, d);
    endtask

    task automatic t_div_zero();
        int seen = 0;
        do_reset();
        div_val = DIV_W'(2);
        tick(6);
        div_val = '0;
        tick(1);
        for (int i = 0; i < 12; i++) begin
            seen |= tx_clk;
            tick(1);
        end
        chk("R2 zero divide holds low", seen, 0);
    endtask

    task automatic t_pad_sync();
        do_reset();
        tx_src = 2'd2;
        tx_pad_in = 1;
        tick(1);
        chk("R4 pad after one edge", tx_clk, 0);
        tick(1);
        chk("R4 pad after two edges", tx_clk, 1);
        chk("R4 rise pulse", tx_rise, 1);
        tick(1);
        chk("R4 rise pulse one cycle", tx_rise, 0);
        chk("R3 pad level held", tx_clk, 1);
    endtask

    task automatic t_peer();
        int mism = 0;
        do_reset();
        tx_src = 2'd2; rx_src = 2'd1;
        tx_pad_in = 1;
        tick(2);
        chk("R3 rx takes tx pad", rx_clk, 1);
        rx_inv = 1;
        settle();
        chk("R5 rx inverted peer", rx_clk, 0);
        rx_inv = 0;
        tx_src = 2'd0; tx_mode = 2'd1; div_val = DIV_W'(2);
        tick(1);
        for (int i = 0; i < 10; i++) begin
            if (rx_clk != tx_pad_out) mism++;
            tick(1);
        end
        chk("R3 rx takes tx divided", mism, 0);
        chk("R10 legal peer no err", cfg_err, 0);
    endtask

    task automatic t_invert();
        int mism = 0;
        int ones = 0;
        do_reset();
        tx_inv = 1;
        settle();
        chk("R5 inverted idle clock", tx_clk, 1);
        tx_mode = 2'd1; div_val = DIV_W'(2);
        tick(1);
        for (int i = 0; i < 12; i++) begin
            if (tx_clk == tx_pad_out) mism++;
            ones += tx_pad_out;
            tick(1);
        end
        chk("R6 pad not inverted", mism, 0);
        chk("R6 pad toggles", ones, 6);
    endtask

    task automatic t_oe_modes();
        int drv = 0;
        do_reset();
        div_val = DIV_W'(1);
        tx_mode = 2'd0; settle();
        chk("R7 mode0 undriven", tx_pad_oe, 0);
        tx_mode = 2'd1; settle();
        chk("R7 mode1 driven", tx_pad_oe, 1);
        tx_mode = 2'd2; tx_active = 0; settle();
        chk("R7 mode2 idle undriven", tx_pad_oe, 0);
        for (int i = 0; i < 4; i++) begin drv |= tx_pad_out; tick(1); end
        chk("R7 undriven pad low", drv, 0);
        tx_active = 1; settle();
        chk("R7 mode2 active driven", tx_pad_oe, 1);
        tx_mode = 2'd3; settle();
        chk("R7 mode3 undriven", tx_pad_oe, 0);
        rx_mode = 2'd2; rx_active = 1; settle();
        chk("R7 rx mode2 active", rx_pad_oe, 1);
    endtask

    task automatic t_contend();
        do_reset();
        rx_src = 2'd2; rx_mode = 2'd1;
        settle();
        chk("R8 rx pad held off", rx_pad_oe, 0);
        chk("R10 err not yet", cfg_err, 0);
        tick(1);
        chk("R10 err after one edge", cfg_err, 1);
        rx_src = 2'd0;
        tick(3);
        chk("R10 err sticky", cfg_err, 1);
        chk("R7 rx mode1 legal again", rx_pad_oe, 1);
        do_reset();
        chk("R10 err cleared by reset", cfg_err, 0);
    endtask

    task automatic t_mutual();
        int mism = 0;
        do_reset();
        div_val = DIV_W'(2); tx_mode = 2'd1;
        tx_src = 2'd1; rx_src = 2'd1;
        tick(1);
        chk("R10 mutual err", cfg_err, 1);
        for (int i = 0; i < 10; i++) begin
            if (tx_clk != tx_pad_out || rx_clk != tx_pad_out) mism++;
            tick(1);
        end
        chk("R9 mutual uses divided", mism, 0);
    endtask

    task automatic t_reserved_src();
        int mism = 0;
        do_reset();
        div_val = DIV_W'(3); tx_mode = 2'd1; tx_src = 2'd3;
        tx_pad_in = 1;
        tick(1);
        for (int i = 0; i < 12; i++) begin
            if (tx_clk != tx_pad_out) mism++;
            tick(1);
        end
        chk("R3 source 3 is divided", mism, 0);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got 0 expected 1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_divider(3);
        t_divider(1);
        t_divider(7);
        t_div_zero();
        t_pad_sync();
        t_peer();
        t_invert();
        t_oe_modes();
        t_contend();
        t_mutual();
        t_reserved_src();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule